// File: doc/BRIEF.md
# Synchronous Dual-Port RAM Core

A two-port static memory in which a left and a right port each run on their own clock and may read or write any word, including the same word in the same cycle. Each word holds 36 bits in four 9-bit lanes. Every control, address and data input is captured in a register on its port's clock. Writes commit one edge later, and only to the lanes that are enabled.

Each port has a static mode input. In flow-through mode, read data leaves the array directly in the cycle after the address edge. In pipelined mode it passes one more output register. In that mode the select and lane enables are delayed through the same extra stage, so a deselect reaches the output two cycles after it is applied. Two chip selects per port, one active-low and one active-high, allow depth expansion without external decode. An asynchronous active-low output enable blanks the read bus to zero. The collision rules below assume both port clocks are the same clock.

Top module: `dp_sram_core`

## Requirements
- R1: After reset the array reads as all zeros, and both read buses are zero.
- R2: Flow-through mode (mode input 0): read data for an address registered at edge k is valid on the read bus after edge k. A write cycle (rw=0) drives zero on the read bus.
- R3: Pipelined mode (mode input 1): read data for an address registered at edge k is valid after edge k+1. After edge k the bus still shows the previous stage.
- R4: A write stores only the lanes whose active-low lane enable is 0. Lane j is bits 9j+8..9j. The other lanes keep their contents.
- R5: A port is selected only when its ce0_n is 0 and its ce1 is 1. A write while deselected leaves memory unchanged, and a deselected cycle drives zero on the read bus.
- R6: In pipelined mode, a deselect applied at edge k still lets the read from edge k-1 appear after edge k. The bus is zero after edge k+1. In flow-through mode the bus is zero after edge k.
- R7: On a read, a lane whose enable is 1 reads as zero. Enabled lanes show the stored data.
- R8: While oe_n is 1 the read bus is zero, with no clock delay. Memory and the read pipeline are unaffected.
- R9: Both ports may read the same word in the same cycle, and both get its contents.
- R10: If both ports write the same word at the same edge, each lane written by the right port takes the right port's data. Lanes written only by the left port take the left data.
- R11: A flow-through read of a word that the other port writes at the same edge returns the old contents.
- R12: Simultaneous writes from both ports to different words both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l_i | input | 1 | Left port clock |
| clk_r_i | input | 1 | Right port clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pl_l_i | input | 1 | Left mode: 1 pipelined, 0 flow-through |
| ce0_l_ni | input | 1 | Left chip select, active low |
| ce1_l_i | input | 1 | Left chip select, active high |
| rw_l_i | input | 1 | Left 1 read, 0 write |
| oe_l_ni | input | 1 | Left output enable, active low |
| be_l_ni | input | 4 | Left lane enables, active low |
| addr_l_i | input | AW | Left word address |
| din_l_i | input | 36 | Left write data |
| dout_l_o | output | 36 | Left read data |
| pl_r_i | input | 1 | Right mode: 1 pipelined, 0 flow-through |
| ce0_r_ni | input | 1 | Right chip select, active low |
| ce1_r_i | input | 1 | Right chip select, active high |
| rw_r_i | input | 1 | Right 1 read, 0 write |
| oe_r_ni | input | 1 | Right output enable, active low |
| be_r_ni | input | 4 | Right lane enables, active low |
| addr_r_i | input | AW | Right word address |
| din_r_i | input | 36 | Right write data |
| dout_r_o | output | 36 | Right read data |

## Verification
The hardest case to reach is a same-edge collision. Both ports must present their requests on the same clock edge, with the same address and overlapping lane masks, or with one port reading while the other writes. The bench drives both clocks from one source and sets both ports' inputs at the same falling edge. It then reads the result back through a later, quiet cycle. It uses partial lane masks, so that the per-lane arbitration shows up as a mix of both ports' data.

// File: rtl/dp_sram_pkg.sv
package dp_sram_pkg;
  typedef enum logic {
    MODE_FLOW = 1'b0,
    MODE_PIPE = 1'b1
  } rd_mode_e;

  localparam int unsigned NPORT = 2;
endpackage

// File: rtl/dp_port_front.sv
module dp_port_front #(
  parameter int unsigned AW = 4,
  parameter int unsigned NB = 4,
  parameter int unsigned BW = 9
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ce0_ni,
  input  logic                   ce1_i,
  input  logic                   rw_i,
  input  logic [NB-1:0]          be_ni,
  input  logic [AW-1:0]          addr_i,
  input  logic [NB-1:0][BW-1:0]  wdata_i,
  output logic [AW-1:0]          addr_o,
  output logic [NB-1:0][BW-1:0]  wdata_o,
  output logic [NB-1:0]          wr_lane_o,
  output logic [NB-1:0]          rd_lane_o
);
  logic          sel_q, rw_q;
  logic [NB-1:0] be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      rw_q    <= 1'b1;
      be_q    <= '0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else begin
      sel_q   <= !ce0_ni && ce1_i;
      rw_q    <= rw_i;
      be_q    <= ~be_ni;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

  assign wr_lane_o = (sel_q && !rw_q) ? be_q : '0;
  assign rd_lane_o = (sel_q &&  rw_q) ? be_q : '0;
endmodule

// File: rtl/dp_mem_half.sv
// One half of an XOR-coded two-writer array: word = left_half ^ right_half.
module dp_mem_half #(
  parameter int unsigned AW    = 4,
  parameter int unsigned NB    = 4,
  parameter int unsigned BW    = 9,
  parameter bit          YIELD = 1'b0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NB-1:0]          wr_lane_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [NB-1:0][BW-1:0]  wdata_i,
  input  logic [NB-1:0][BW-1:0]  peer_word_i,
  input  logic [NB-1:0]          peer_wr_lane_i,
  input  logic [AW-1:0]          peer_addr_i,
  output logic [NB-1:0][BW-1:0]  own_mine_o,
  output logic [NB-1:0][BW-1:0]  own_peer_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [NB-1:0][BW-1:0] arr_q [DEPTH];
  logic [NB-1:0]         lane_go;

  // the yielding half drops lanes the peer writes at the same address
  assign lane_go = (YIELD && (peer_addr_i == addr_i)) ? (wr_lane_i & ~peer_wr_lane_i)
                                                     : wr_lane_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < DEPTH; w++) arr_q[w] <= '0;
    end else begin
      for (int j = 0; j < NB; j++)
        if (lane_go[j]) arr_q[addr_i][j] <= wdata_i[j] ^ peer_word_i[j];
    end
  end

  assign own_mine_o = arr_q[addr_i];
  assign own_peer_o = arr_q[peer_addr_i];
endmodule

// File: rtl/dp_rd_path.sv
module dp_rd_path #(
  parameter int unsigned NB = 4,
  parameter int unsigned BW = 9
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  dp_sram_pkg::rd_mode_e  mode_i,
  input  logic                   oe_ni,
  input  logic [NB-1:0]          rd_lane_i,
  input  logic [NB-1:0][BW-1:0]  word_i,
  output logic [NB-1:0][BW-1:0]  dout_o
);
  logic [NB-1:0][BW-1:0] word_q, lanes;
  logic [NB-1:0]         lane_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      lane_q <= '0;
    end else begin
      word_q <= word_i;
      lane_q <= rd_lane_i;
    end
  end

  for (genvar j = 0; j < NB; j++) begin : g_lane
    always_comb begin
      if (mode_i == dp_sram_pkg::MODE_PIPE) lanes[j] = lane_q[j]    ? word_q[j] : '0;
      else                                  lanes[j] = rd_lane_i[j] ? word_i[j] : '0;
    end
  end

  assign dout_o = oe_ni ? '0 : lanes;
endmodule

// File: rtl/dp_sram_core.sv
module dp_sram_core #(
  parameter int unsigned AW = 4,
  parameter int unsigned NB = 4,
  parameter int unsigned BW = 9,
  localparam int unsigned DW = NB * BW
) (
  input  logic          clk_l_i,
  input  logic          clk_r_i,
  input  logic          rst_ni,
  input  logic          pl_l_i,
  input  logic          ce0_l_ni,
  input  logic          ce1_l_i,
  input  logic          rw_l_i,
  input  logic          oe_l_ni,
  input  logic [NB-1:0] be_l_ni,
  input  logic [AW-1:0] addr_l_i,
  input  logic [DW-1:0] din_l_i,
  output logic [DW-1:0] dout_l_o,
  input  logic          pl_r_i,
  input  logic          ce0_r_ni,
  input  logic          ce1_r_i,
  input  logic          rw_r_i,
  input  logic          oe_r_ni,
  input  logic [NB-1:0] be_r_ni,
  input  logic [AW-1:0] addr_r_i,
  input  logic [DW-1:0] din_r_i,
  output logic [DW-1:0] dout_r_o
);
  import dp_sram_pkg::*;

  logic                  clk [NPORT];
  logic                  pl [NPORT], ce0_n [NPORT], ce1 [NPORT], rw [NPORT], oe_n [NPORT];
  logic [NB-1:0]         be_n [NPORT];
  logic [AW-1:0]         addr [NPORT], addr_q [NPORT];
  logic [NB-1:0][BW-1:0] din [NPORT], wd_q [NPORT], dout [NPORT];
  logic [NB-1:0][BW-1:0] own_mine [NPORT], own_peer [NPORT], word [NPORT];
  logic [NB-1:0]         wr_ln [NPORT], rd_ln [NPORT];

  assign clk[0] = clk_l_i;   assign clk[1] = clk_r_i;
  assign pl[0] = pl_l_i;     assign pl[1] = pl_r_i;
  assign ce0_n[0] = ce0_l_ni; assign ce0_n[1] = ce0_r_ni;
  assign ce1[0] = ce1_l_i;   assign ce1[1] = ce1_r_i;
  assign rw[0] = rw_l_i;     assign rw[1] = rw_r_i;
  assign oe_n[0] = oe_l_ni;  assign oe_n[1] = oe_r_ni;
  assign be_n[0] = be_l_ni;  assign be_n[1] = be_r_ni;
  assign addr[0] = addr_l_i; assign addr[1] = addr_r_i;
  assign din[0] = din_l_i;   assign din[1] = din_r_i;
  assign dout_l_o = dout[0];
  assign dout_r_o = dout[1];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int unsigned Q = NPORT - 1 - p;

    dp_port_front #(.AW(AW), .NB(NB), .BW(BW)) u_front (
      .clk_i(clk[p]), .rst_ni(rst_ni), .ce0_ni(ce0_n[p]), .ce1_i(ce1[p]),
      .rw_i(rw[p]), .be_ni(be_n[p]), .addr_i(addr[p]), .wdata_i(din[p]),
      .addr_o(addr_q[p]), .wdata_o(wd_q[p]), .wr_lane_o(wr_ln[p]), .rd_lane_o(rd_ln[p])
    );

    // left half yields so the right port wins a same-word collision
    dp_mem_half #(.AW(AW), .NB(NB), .BW(BW), .YIELD(p == 0)) u_half (
      .clk_i(clk[p]), .rst_ni(rst_ni), .wr_lane_i(wr_ln[p]), .addr_i(addr_q[p]),
      .wdata_i(wd_q[p]), .peer_word_i(own_peer[Q]), .peer_wr_lane_i(wr_ln[Q]),
      .peer_addr_i(addr_q[Q]), .own_mine_o(own_mine[p]), .own_peer_o(own_peer[p])
    );

    assign word[p] = own_mine[p] ^ own_peer[Q];

    dp_rd_path #(.NB(NB), .BW(BW)) u_rd (
      .clk_i(clk[p]), .rst_ni(rst_ni), .mode_i(rd_mode_e'(pl[p])), .oe_ni(oe_n[p]),
      .rd_lane_i(rd_ln[p]), .word_i(word[p]), .dout_o(dout[p])
    );
  end
endmodule

// File: rtl/dp_sram_core_chk.sv
module dp_sram_core_chk #(
  parameter int unsigned AW = 4,
  parameter int unsigned NB = 4,
  parameter int unsigned BW = 9,
  localparam int unsigned DW = NB * BW
) (
  input logic          clk_l_i,
  input logic          clk_r_i,
  input logic          rst_ni,
  input logic          pl_l_i,
  input logic          ce0_l_ni,
  input logic          ce1_l_i,
  input logic          rw_l_i,
  input logic          oe_l_ni,
  input logic [NB-1:0] be_l_ni,
  input logic [DW-1:0] dout_l_o,
  input logic          oe_r_ni,
  input logic [DW-1:0] dout_r_o
);
  AST_OE_IDLE_L: assert property (@(posedge clk_l_i) disable iff (!rst_ni)
    oe_l_ni |-> dout_l_o == '0); // R8
  AST_OE_IDLE_R: assert property (@(posedge clk_r_i) disable iff (!rst_ni)
    oe_r_ni |-> dout_r_o == '0); // R8
  AST_FT_WRITE_IDLE: assert property (@(posedge clk_l_i) disable iff (!rst_ni)
    (!pl_l_i && !$past(rw_l_i)) |-> dout_l_o == '0); // R2
  AST_FT_DESELECT: assert property (@(posedge clk_l_i) disable iff (!rst_ni)
    (!pl_l_i && ($past(ce0_l_ni) || !$past(ce1_l_i))) |-> dout_l_o == '0); // R5
  AST_PL_DESELECT: assert property (@(posedge clk_l_i) disable iff (!rst_ni)
    (pl_l_i && ($past(ce0_l_ni, 2) || !$past(ce1_l_i, 2))) |-> dout_l_o == '0); // R6

  for (genvar j = 0; j < NB; j++) begin : g_ln
    AST_FT_LANE_OFF: assert property (@(posedge clk_l_i) disable iff (!rst_ni)
      (!pl_l_i && $past(be_l_ni[j])) |-> dout_l_o[j*BW +: BW] == '0); // R7
  end
endmodule

bind dp_sram_core dp_sram_core_chk #(.AW(AW), .NB(NB), .BW(BW)) u_chk (
  .clk_l_i(clk_l_i), .clk_r_i(clk_r_i), .rst_ni(rst_ni), .pl_l_i(pl_l_i),
  .ce0_l_ni(ce0_l_ni), .ce1_l_i(ce1_l_i), .rw_l_i(rw_l_i), .oe_l_ni(oe_l_ni),
  .be_l_ni(be_l_ni), .dout_l_o(dout_l_o), .oe_r_ni(oe_r_ni), .dout_r_o(dout_r_o)
);

// File: tb/dp_sram_core_test.sv
module dp_sram_core_test;
  localparam int unsigned PERIOD = 10;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 36;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pl_l = 0, ce0_l = 1, ce1_l = 0, rw_l = 1, oe_l = 0;
  logic pl_r = 0, ce0_r = 1, ce1_r = 0, rw_r = 1, oe_r = 0;
  logic [3:0] be_l = '1, be_r = '1;
  logic [AW-1:0] a_l = '0, a_r = '0;
  logic [DW-1:0] d_l = '0, d_r = '0, q_l, q_r;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  dp_sram_core #(.AW(AW)) uut (
    .clk_l_i(clk), .clk_r_i(clk), .rst_ni(rst_ni),
    .pl_l_i(pl_l), .ce0_l_ni(ce0_l), .ce1_l_i(ce1_l), .rw_l_i(rw_l), .oe_l_ni(oe_l),
    .be_l_ni(be_l), .addr_l_i(a_l), .din_l_i(d_l), .dout_l_o(q_l),
    .pl_r_i(pl_r), .ce0_r_ni(ce0_r), .ce1_r_i(ce1_r), .rw_r_i(rw_r), .oe_r_ni(oe_r),
    .be_r_ni(be_r), .addr_r_i(a_r), .din_r_i(d_r), .dout_r_o(q_r)
  );

  function automatic logic [DW-1:0] lmask(logic [3:0] ben);
    logic [DW-1:0] m = '0;
    for (int j = 0; j < 4; j++) if (!ben[j]) m[j*9 +: 9] = '1;
    return m;
  endfunction

  task automatic chk(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic idle;
    ce0_l = 1; ce1_l = 0; rw_l = 1; be_l = '1;
    ce0_r = 1; ce1_r = 0; rw_r = 1; be_r = '1;
  endtask

  task automatic set_l(logic w, logic [3:0] ben, logic [AW-1:0] a, logic [DW-1:0] d);
    ce0_l = 0; ce1_l = 1; rw_l = !w; be_l = ben; a_l = a; d_l = d;
  endtask

  task automatic set_r(logic w, logic [3:0] ben, logic [AW-1:0] a, logic [DW-1:0] d);
    ce0_r = 0; ce1_r = 1; rw_r = !w; be_r = ben; a_r = a; d_r = d;
  endtask

  // flow-through read on the left, value after the address edge
  task automatic rd_l(logic [AW-1:0] a, logic [3:0] ben, output logic [DW-1:0] v);
    set_l(0, ben, a, '0); tick; v = q_l; idle;
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    chk("R1 left bus after reset", q_l, '0);
    chk("R1 right bus after reset", q_r, '0);
    rd_l(4'd9, 4'b0000, v);
    chk("R1 array zero after reset", v, '0);
  endtask

  task automatic t_flow;
    logic [DW-1:0] v;
    set_l(1, 4'b0000, 4'd3, 36'h1_2345_6789); tick;
    chk("R2 write cycle bus idle", q_l, '0);
    idle; tick;
    rd_l(4'd3, 4'b0000, v);
    chk("R2 flow read", v, 36'h1_2345_6789);
    tick;
    set_l(0, 4'b0000, 4'd3, '0); set_r(0, 4'b0000, 4'd3, '0); tick;
    chk("R9 left same-word read", q_l, 36'h1_2345_6789);
    chk("R9 right same-word read", q_r, 36'h1_2345_6789);
    idle; tick;
  endtask

  task automatic t_pipe;
    pl_l = 1; tick; tick;
    set_l(0, 4'b0000, 4'd3, '0); tick;
    chk("R3 pipe not yet", q_l, '0);
    idle; tick;
    chk("R3 pipe data", q_l, 36'h1_2345_6789);
    tick;
    set_l(0, 4'b0000, 4'd3, '0); tick;
    ce1_l = 0; tick;
    chk("R6 pipe read survives deselect", q_l, 36'h1_2345_6789);
    idle; tick;
    chk("R6 pipe deselect after two", q_l, '0);
    pl_l = 0; tick;
    set_l(0, 4'b0000, 4'd3, '0); tick;
    chk("R6 flow read before deselect", q_l, 36'h1_2345_6789);
    ce0_l = 1; tick;
    chk("R6 flow deselect after one", q_l, '0);
    idle; tick;
  endtask

  task automatic t_lanes;
    logic [DW-1:0] v, base, nw, exp;
    base = 36'hA_BCDE_F012; nw = 36'h5_5555_5555;
    set_l(1, 4'b0000, 4'd5, base); tick;
    set_l(1, 4'b1010, 4'd5, nw); tick;
    idle; tick;
    exp = (base & ~lmask(4'b1010)) | (nw & lmask(4'b1010));
    rd_l(4'd5, 4'b0000, v);
    chk("R4 lane-masked write", v, exp);
    rd_l(4'd5, 4'b0110, v);
    chk("R7 disabled lanes read zero", v, exp & lmask(4'b0110));
  endtask

  task automatic t_ce;
    logic [DW-1:0] v;
    set_l(1, 4'b0000, 4'd3, 36'hF_FFFF_FFFF); ce0_l = 1; tick;
    set_l(1, 4'b0000, 4'd3, 36'hE_EEEE_EEEE); ce1_l = 0; tick;
    idle; tick;
    set_l(0, 4'b0000, 4'd3, '0); ce1_l = 0; tick;
    chk("R5 deselected read bus idle", q_l, '0);
    idle;
    rd_l(4'd3, 4'b0000, v);
    chk("R5 deselected writes ignored", v, 36'h1_2345_6789);
  endtask

  task automatic t_oe;
    set_l(0, 4'b0000, 4'd3, '0); oe_l = 1; tick;
    chk("R8 oe high blanks bus", q_l, '0);
    oe_l = 0; #1;
    chk("R8 oe low restores at once", q_l, 36'h1_2345_6789);
    idle; tick;
  endtask

  task automatic t_collide;
    logic [DW-1:0] v, dl, dr;
    dl = 36'h1_1111_1111; dr = 36'h2_2222_2222;
    set_l(1, 4'b0000, 4'd7, dl); set_r(1, 4'b0011, 4'd7, dr); tick;
    idle; tick;
    rd_l(4'd7, 4'b0000, v);
    chk("R10 right wins shared lanes", v, (dr & lmask(4'b0011)) | (dl & ~lmask(4'b0011)));
    set_l(0, 4'b0000, 4'd3, '0); set_r(1, 4'b0000, 4'd3, 36'h3_3333_3333); tick;
    chk("R11 read during peer write old", q_l, 36'h1_2345_6789);
    idle; tick;
    rd_l(4'd3, 4'b0000, v);
    chk("R11 peer write landed", v, 36'h3_3333_3333);
    set_l(1, 4'b0000, 4'd8, 36'h4_4444_4444); set_r(1, 4'b0000, 4'd9, 36'h6_6666_6666); tick;
    idle; tick;
    rd_l(4'd8, 4'b0000, v);
    chk("R12 left write kept", v, 36'h4_4444_4444);
    set_r(0, 4'b0000, 4'd9, '0); tick;
    chk("R12 right write kept", q_r, 36'h6_6666_6666);
    idle; tick;
  endtask

  initial begin
    #(PERIOD * 50000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick; tick;
    rst_ni = 1'b1;
    tick;
    t_reset;
    t_flow;
    t_pipe;
    t_lanes;
    t_ce;
    t_oe;
    t_collide;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule